// File: doc/BRIEF.md
# Serial Skew-Delay Register Loader

This block receives a write-only, three-wire serial stream and loads the settings of a three-channel skew compensator. The stream has an active-low frame enable, a serial clock and a data line. Each channel has a 5-bit delay code. A fourth test register holds a 4-bit slice-level code. All three serial lines are synchronized into the system clock domain. A bit is taken when a falling serial clock edge is detected and the frame enable is low. Bits are collected MSB first into 8-bit words, and one frame may carry several words back to back.

Each complete word is decoded when its eighth bit arrives. A word with an illegal leading bit, an out-of-range code or a malformed test pattern is dropped. When the frame closes, the block raises a one-cycle `write_done_o` pulse if that frame changed any register. A downstream sequencer can use this pulse to start recalibration. A falling frame enable always restarts word alignment, so a bad frame is repaired by sending a new frame of the correct size.

Top module: `skew_prog_rx`

## Requirements
- R1: After reset all three delay codes and the slice code read zero and `write_done_o` is low.
- R2: Bits are taken on falling `sclk_i` edges while `sen_ni` is low, MSB first. In a word, bit 7 must be 0, bits 6:5 select the target (01 red, 10 green, 11 blue) and bits 4:0 are the delay code, applied once the eighth bit arrives.
- R3: Target 00 is the test register. Its word is 000wxyz0, and bits 4:1 load `slice_o`. A test word whose bit 0 is 1 is discarded.
- R4: A word whose bit 7 is 1 is discarded and every register keeps its value.
- R5: Consecutive 8-bit words in one frame are each decoded in turn, so a 24-bit burst loads three registers.
- R6: A falling `sen_ni` restarts the bit count, so a frame sent after a short frame is aligned correctly.
- R7: A trailing group of fewer than 8 bits when `sen_ni` rises changes nothing.
- R8: `write_done_o` is a single-cycle pulse after `sen_ni` rises, and only if at least one word was applied in that frame.
- R9: A delay code above parameter `MAX_CODE` is discarded and the target register keeps its value.
- R10: `sclk_i` edges while `sen_ni` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sen_ni | input | 1 | Serial frame enable, active low |
| sclk_i | input | 1 | Serial clock, data taken on falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| dly_red_o | output | 5 | Red channel delay code |
| dly_grn_o | output | 5 | Green channel delay code |
| dly_blu_o | output | 5 | Blue channel delay code |
| slice_o | output | 4 | Test slice-level code |
| write_done_o | output | 1 | One-cycle pulse: frame applied at least one word |

## Verification
Random frames of one to three words exercise the decoder. The words mix valid channel writes, test writes with a good or bad bit 0, and words with bit 7 set, and some frames end in a ragged tail. These frames separate correct word alignment from off-by-one counting and show that each discard rule leaves the registers intact. Directed cases cover a short frame followed by a clean one (count restart), serial clock toggling with the enable high, and frames made only of rejected words, where no done pulse may appear. A second instance with a 15-step limit shows that codes above the limit are rejected while codes at the limit are accepted.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
  localparam int WORD_W  = 8;
  localparam int CODE_W  = 5;
  localparam int SLICE_W = 4;
  localparam int NUM_CH  = 3;
  localparam int CNT_W   = $clog2(WORD_W);

  typedef enum logic [1:0] {
    TGT_TEST = 2'b00,
    TGT_RED  = 2'b01,
    TGT_GRN  = 2'b10,
    TGT_BLU  = 2'b11
  } tgt_e;
endpackage

// File: rtl/sprx_sync.sv
module sprx_sync #(
  parameter int         STAGES  = 2,
  parameter int         WIDTH   = 3,
  parameter logic [2:0] RST_VAL = 3'b110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  logic [WIDTH-1:0] pipe [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL[WIDTH-1:0];
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o      = pipe[STAGES-1];
  assign q_prev_o = pipe[STAGES];
endmodule

// File: rtl/sprx_shift.sv
module sprx_shift
  import sprx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_fall_i,
  input  logic              sen_low_i,
  input  logic              sclk_fall_i,
  input  logic              bit_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sh_q;
  logic              take;

  assign take = sen_low_i & sclk_fall_i & ~sen_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= take & (cnt_q == LAST);
      if (take) word_o <= {sh_q, bit_i};
      if (sen_fall_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= {sh_q[WORD_W-3:0], bit_i};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_fall_i |=> (cnt_q == '0)); // R6
  AST_NO_IDLE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_low_i |=> !word_vld_o); // R10
endmodule

// File: rtl/sprx_regs.sv
module sprx_regs
  import sprx_pkg::*;
#(
  parameter int MAX_CODE = 31
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          word_vld_i,
  input  logic [WORD_W-1:0]             word_i,
  output logic [NUM_CH-1:0][CODE_W-1:0] dly_o,
  output logic [SLICE_W-1:0]            slice_o,
  output logic                          wr_o
);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

  logic              lead;
  tgt_e              tgt;
  logic [CODE_W-1:0] code;
  logic              ok_ch, ok_test;

  assign lead    = word_i[WORD_W-1];
  assign tgt     = tgt_e'(word_i[WORD_W-2 -: 2]);
  assign code    = word_i[CODE_W-1:0];
  assign ok_ch   = word_vld_i & ~lead & (tgt != TGT_TEST) & (code <= MAX_C);
  assign ok_test = word_vld_i & ~lead & (tgt == TGT_TEST) & ~word_i[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    dly_o[g] <= '0;
      else if (ok_ch && (word_i[WORD_W-2 -: 2] == 2'(g + 1))) dly_o[g] <= code;
    end

    AST_CODE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dly_o[g] <= MAX_C); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slice_o <= '0;
      wr_o    <= 1'b0;
    end else begin
      if (ok_test) slice_o <= word_i[SLICE_W:1];
      wr_o <= ok_ch | ok_test;
    end
  end

  AST_LEAD_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && lead) |=> ($stable(dly_o) && $stable(slice_o) && !wr_o)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_i |=> ($stable(dly_o) && $stable(slice_o))); // R7
endmodule

// File: rtl/skew_prog_rx.sv
module skew_prog_rx
  import sprx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_CODE    = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sen_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  output logic [CODE_W-1:0]  dly_red_o,
  output logic [CODE_W-1:0]  dly_grn_o,
  output logic [CODE_W-1:0]  dly_blu_o,
  output logic [SLICE_W-1:0] slice_o,
  output logic               write_done_o
);
  logic [2:0] s_q, s_prev;
  logic       sen_fall, sen_rise, sclk_fall;
  logic       word_vld, wr;
  logic [WORD_W-1:0] word;
  logic [NUM_CH-1:0][CODE_W-1:0] dly;
  logic       frame_hit_q;

  // idle: enable high, clock high, data low
  sprx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b110)) u_sync (
    .clk_i, .rst_ni,
    .d_i      ({sen_ni, sclk_i, sdata_i}),
    .q_o      (s_q),
    .q_prev_o (s_prev)
  );

  assign sen_fall  =  s_prev[2] & ~s_q[2];
  assign sen_rise  = ~s_prev[2] &  s_q[2];
  assign sclk_fall =  s_prev[1] & ~s_q[1];

  sprx_shift u_shift (
    .clk_i, .rst_ni,
    .sen_fall_i  (sen_fall),
    .sen_low_i   (~s_q[2]),
    .sclk_fall_i (sclk_fall),
    .bit_i       (s_q[0]),
    .word_vld_o  (word_vld),
    .word_o      (word)
  );

  sprx_regs #(.MAX_CODE(MAX_CODE)) u_regs (
    .clk_i, .rst_ni,
    .word_vld_i (word_vld),
    .word_i     (word),
    .dly_o      (dly),
    .slice_o    (slice_o),
    .wr_o       (wr)
  );

  assign dly_red_o = dly[0];
  assign dly_grn_o = dly[1];
  assign dly_blu_o = dly[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_hit_q  <= 1'b0;
      write_done_o <= 1'b0;
    end else begin
      write_done_o <= sen_rise & (frame_hit_q | wr);
      if (sen_rise || sen_fall) frame_hit_q <= 1'b0;
      else if (wr)              frame_hit_q <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_done_o |=> !write_done_o); // R8
  AST_DONE_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_done_o |-> $past(sen_rise)); // R8
endmodule

// File: tb/tb_skew_prog_rx.sv
module tb_skew_prog_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sen_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
  logic [4:0] red, grn, blu, red15, grn15, blu15;
  logic [3:0] slice, slice15;
  logic done, done15;
  int checks = 0, fails = 0, pulses = 0;
  logic [4:0] e_dly [3];
  logic [4:0] e15 [3];
  logic [3:0] e_slice;
  logic e_any;
  bit finished = 0;

  always #10 clk = ~clk;

  skew_prog_rx dut (.clk_i(clk), .rst_ni(rst_n), .sen_ni(sen_n), .sclk_i(sclk),
    .sdata_i(sdata), .dly_red_o(red), .dly_grn_o(grn), .dly_blu_o(blu),
    .slice_o(slice), .write_done_o(done));
  skew_prog_rx #(.MAX_CODE(15)) dut15 (.clk_i(clk), .rst_ni(rst_n), .sen_ni(sen_n),
    .sclk_i(sclk), .sdata_i(sdata), .dly_red_o(red15), .dly_grn_o(grn15),
    .dly_blu_o(blu15), .slice_o(slice15), .write_done_o(done15));

  always @(negedge clk) if (done) pulses++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of one complete word
  task automatic model_word(logic [7:0] w);
    if (w[7]) return;
    if (w[6:5] == 2'b00) begin
      if (!w[0]) begin e_slice = w[4:1]; e_any = 1; end
    end else begin
      e_dly[w[6:5]-1] = w[4:0]; e_any = 1;
      if (w[4:0] <= 5'd15) e15[w[6:5]-1] = w[4:0];
    end
  endtask

  task automatic send_frame(logic [31:0] bits, int nbits);
    e_any = 0;
    for (int k = 0; k < nbits / 8; k++) model_word(bits[nbits-1-8*k -: 8]);
    sen_n = 1'b0; wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = bits[i]; wait_clk(4);
      sclk = 1'b0;     wait_clk(4);
      sclk = 1'b1;
    end
    wait_clk(4); sen_n = 1'b1; wait_clk(10);
  endtask

  task automatic check_all(string req, int p0);
    chk({req, " red"},   red,   e_dly[0]);
    chk({req, " green"}, grn,   e_dly[1]);
    chk({req, " blue"},  blu,   e_dly[2]);
    chk({req, " slice"}, slice, e_slice);
    chk({req, " R9 red15"},  red15, e15[0]);
    chk({req, " R9 grn15"},  grn15, e15[1]);
    chk({req, " R9 blu15"},  blu15, e15[2]);
    chk({req, " R8 pulses"}, pulses - p0, e_any ? 1 : 0);
  endtask

  task automatic finish_up();
    if (finished) return;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] rand_word();
    logic [7:0] w;
    w = 8'($urandom);
    if ($urandom_range(0, 7) != 0) w[7] = 1'b0;
    if (w[6:5] == 2'b00 && $urandom_range(0, 3) != 0) w[0] = 1'b0;
    return w;
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    int p0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin e_dly[i] = '0; e15[i] = '0; end
    e_slice = '0; e_any = 0;
    wait_clk(3); rst_n = 1'b1; wait_clk(3);
    // R1 reset state
    chk("R1 red", red, 0); chk("R1 green", grn, 0); chk("R1 blue", blu, 0);
    chk("R1 slice", slice, 0); chk("R1 done", done, 0);

    // R2 single red word 0_01_10110
    p0 = pulses; send_frame(32'h36, 8); check_all("R2", p0);
    // R5 burst green, blue, red
    p0 = pulses; send_frame({8'b0, 8'b0100_1111, 8'b0110_0001, 8'b0010_0011}, 24);
    check_all("R5", p0);
    // R3 test word 000_1011_0 -> slice 1011
    p0 = pulses; send_frame(32'b0001_0110, 8); check_all("R3", p0);
    // R3 test word with bit0 set is dropped
    p0 = pulses; send_frame(32'b0000_0101, 8); check_all("R3 bad lsb", p0);
    // R4 leading one dropped
    p0 = pulses; send_frame(32'b1011_1111, 8); check_all("R4", p0);
    // R9 code 16 and 15 on dut15 via blue
    p0 = pulses; send_frame({16'b0, 8'b0111_0000, 8'b0110_1111}, 16); check_all("R9", p0);
    // R7 short frame only
    p0 = pulses; send_frame(32'b10101, 5); check_all("R7", p0);
    // R6 realign after short frame
    p0 = pulses; send_frame(32'b0010_1010, 8); check_all("R6", p0);
    // R10 clock toggles with enable high
    p0 = pulses;
    for (int i = 0; i < 8; i++) begin
      sdata = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4); sclk = 1'b1;
    end
    wait_clk(10); e_any = 0; check_all("R10", p0);

    // random frames
    for (int f = 0; f < 40; f++) begin
      logic [31:0] b;
      int nw, tail, nb;
      nw = $urandom_range(1, 3);
      tail = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      b = '0;
      for (int k = 0; k < nw; k++) b = {b[23:0], rand_word()};
      nb = 8 * nw;
      if (tail != 0) begin
        b = (b << tail) | 32'($urandom_range(0, (1 << tail) - 1));
        nb = nb + tail;
      end
      p0 = pulses; send_frame(b, nb); check_all("R5 random", p0);
    end
    finish_up();
  end
endmodule